// File: doc/BRIEF.md
# ATA PIO Host Cycle Sequencer

This block runs one programmed-I/O access on an ATA drive bus for each request, either a register access or a data access. A request presents an address, a direction, a width flag (byte register access or 16-bit data word) and write data. The sequencer drives the address and then opens an address-valid window. It pulses the read or write strobe low, keeps the address and any write data stable for a programmed time after the strobe, and waits out a recovery gap. When the gap is over it acknowledges the request for one clock. For reads, the returned word is captured as the strobe closes.

Every phase length is a count of system clock cycles held in a small set of timing registers, so a single netlist can serve all PIO modes at any clock rate. Firmware loads the counts that meet the nanosecond minimums for the chosen mode. The recovery gap is stretched when needed so that a full access never runs shorter than the programmed cycle-time count. The drive can lengthen the strobe by pulling its ready line low. That line passes through a two-flop synchronizer. If it stays low longer than the programmed timeout, the strobe is ended and an error flag is raised.

Top module: `pio_cycle_seq`

## Requirements
- R1: After reset, both strobes are high, addr_vld, dd_oe, ack and tmo_err are low, and the sequencer is idle.
- R2: A request sampled while idle starts an access. addr_vld is high with both strobes high for L(t1) cycles, where L(v) is v, or 1 when v is 0.
- R3: The strobe is dior_n for reads (req_wr=0) and diow_n for writes (req_wr=1). With the ready line high, it stays low for L(t2w) cycles when req_byte=0 and L(t2b) cycles when req_byte=1.
- R4: After the strobe rises, addr_vld stays high for L(t9) cycles on reads and L(max(t9,t4)) cycles on writes. ata_addr holds the request address throughout and never changes while addr_vld is high.
- R5: On writes, dd_oe is high and dd_out equals the request data from the first setup cycle through the strobe and for exactly t4 cycles after the strobe rises. dd_oe is never high on reads.
- R6: The recovery gap between addr_vld falling and ack lasts max(L(t2i), t0 − A) cycles, where A is the number of cycles addr_vld was high.
- R7: ack is high for exactly one cycle at the end of recovery. After that, a new request is accepted.
- R8: On reads, rdata takes the value of dd_in present during the last cycle the strobe is low.
- R9: While the synchronized ready line is low, the strobe counter is frozen. If iordy rises during strobe cycle r (counting from 0) after being low since before the strobe, the strobe lasts r+2+L(t2) cycles.
- R10: If the ready line stays low for L(tmo) strobe cycles, the strobe ends after that many cycles. tmo_err is then set and stays set until the next request is accepted.
- R11: Timing register writes are taken only while idle. A write presented during an access leaves the register unchanged.
- R12: cfg_sel selects the register: 0 t1, 1 t2w, 2 t2b, 3 t2i, 4 t4, 5 t9, 6 t0, 7 tmo.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Timing register write enable |
| cfg_sel | input | 3 | Timing register select |
| cfg_val | input | CW | Timing count to load |
| req | input | 1 | Access request, sampled while idle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = byte register access, 0 = 16-bit data |
| req_addr | input | AW | Drive register address |
| req_wdata | input | DW | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | DW | Captured read data |
| tmo_err | output | 1 | Ready-line timeout flag |
| ata_addr | output | AW | Address to the drive |
| addr_vld | output | 1 | Address-valid window |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| dd_out | output | DW | Write data to the drive |
| dd_oe | output | 1 | Write data output enable |
| dd_in | input | DW | Read data from the drive |
| iordy | input | 1 | Drive ready, low requests a wait |

## Verification
The bench measures each phase length in clocks for settings where a different term wins: t0 padding dominates in one case and the recovery count in another, t4 dominates address hold on a write but is ignored on a read, and zero counts must still give one cycle. A design that summed the phases wrongly or ignored the byte flag would show a wrong setup, strobe, hold or recovery count. The ready line is released mid-strobe to check the two-cycle synchronizer delay and the frozen counter, and is held low to check that the timeout ends the strobe and sets a flag that clears on the next request. A register write issued during an access must not change the next access, which catches a write path that is not gated by the idle state.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;
  localparam int NREG = 8;

  localparam logic [2:0] SEL_T1  = 3'd0;
  localparam logic [2:0] SEL_T2W = 3'd1;
  localparam logic [2:0] SEL_T2B = 3'd2;
  localparam logic [2:0] SEL_T2I = 3'd3;
  localparam logic [2:0] SEL_T4  = 3'd4;
  localparam logic [2:0] SEL_T9  = 3'd5;
  localparam logic [2:0] SEL_T0  = 3'd6;
  localparam logic [2:0] SEL_TMO = 3'd7;

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_STRB, S_HOLD, S_RECOV, S_ACK
  } pio_st_e;

  // a programmed count of zero still yields one cycle
  function automatic int unsigned ph_len(input int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

  // address hold after strobe; writes also cover the data hold
  function automatic int unsigned hold_len(input int unsigned t9,
                                           input int unsigned t4,
                                           input logic wr);
    if (wr && (t4 > t9)) return ph_len(t4);
    return ph_len(t9);
  endfunction

  // recovery ends once its own minimum and the cycle-time floor are met
  function automatic logic recov_done(input int unsigned rcnt,
                                      input int unsigned tot,
                                      input int unsigned t2i,
                                      input int unsigned t0);
    return ((rcnt + 1) >= ph_len(t2i)) && ((tot + 1) >= t0);
  endfunction
endpackage

// File: rtl/pio_sync2.sv
module pio_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic s1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      q  <= 1'b1;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/pio_timing_regs.sv
module pio_timing_regs #(
  parameter int CW      = 8,
  parameter int RST_CNT = 2,
  parameter int RST_TMO = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    sel,
  input  logic [CW-1:0] val,
  output logic [CW-1:0] t_q [pio_seq_pkg::NREG]
);
  import pio_seq_pkg::*;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [CW-1:0] RV = (i == int'(SEL_TMO)) ? CW'(RST_TMO) : CW'(RST_CNT);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          t_q[i] <= RV;
      else if (wr_en && (sel == 3'(i)))    t_q[i] <= val;
    end
  end
endmodule

// File: rtl/pio_cycle_seq.sv
module pio_cycle_seq #(
  parameter int CW = 8,
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [CW-1:0] cfg_val,
  input  logic          req,
  input  logic          req_wr,
  input  logic          req_byte,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          ack,
  output logic [DW-1:0] rdata,
  output logic          tmo_err,
  output logic [AW-1:0] ata_addr,
  output logic          addr_vld,
  output logic          dior_n,
  output logic          diow_n,
  output logic [DW-1:0] dd_out,
  output logic          dd_oe,
  input  logic [DW-1:0] dd_in,
  input  logic          iordy
);
  import pio_seq_pkg::*;

  localparam int TW = CW + 1;

  pio_st_e       st, st_nx;
  logic [CW-1:0] cnt, wcnt;
  logic [TW-1:0] tot;
  logic          lat_wr, lat_byte;
  logic [AW-1:0] lat_addr;
  logic [DW-1:0] lat_wdata;
  logic          iordy_s;
  logic [CW-1:0] treg [NREG];
  logic [CW-1:0] t2_cur;

  // named internal events
  logic ev_accept, ev_setup_end, ev_strb_end, ev_timeout, ev_hold_end, ev_recov_end;
  logic stall, cfg_take;

  assign cfg_take = cfg_we && (st == S_IDLE);

  pio_timing_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_take), .sel(cfg_sel), .val(cfg_val), .t_q(treg)
  );

  pio_sync2 u_rdy (.clk(clk), .rst_n(rst_n), .d(iordy), .q(iordy_s));

  assign t2_cur       = lat_byte ? treg[SEL_T2B] : treg[SEL_T2W];
  assign ev_accept    = (st == S_IDLE) && req;
  assign ev_setup_end = (st == S_SETUP) && ((32'(cnt) + 1) >= ph_len(32'(treg[SEL_T1])));
  assign stall        = (st == S_STRB) && !iordy_s;
  assign ev_timeout   = stall && ((32'(wcnt) + 1) >= ph_len(32'(treg[SEL_TMO])));
  assign ev_strb_end  = (st == S_STRB) &&
                        ((!stall && ((32'(cnt) + 1) >= ph_len(32'(t2_cur)))) || ev_timeout);
  assign ev_hold_end  = (st == S_HOLD) &&
                        ((32'(cnt) + 1) >= hold_len(32'(treg[SEL_T9]), 32'(treg[SEL_T4]), lat_wr));
  assign ev_recov_end = (st == S_RECOV) &&
                        recov_done(32'(cnt), 32'(tot), 32'(treg[SEL_T2I]), 32'(treg[SEL_T0]));

  always_comb begin
    st_nx = st;
    unique case (st)
      S_IDLE:  if (ev_accept)    st_nx = S_SETUP;
      S_SETUP: if (ev_setup_end) st_nx = S_STRB;
      S_STRB:  if (ev_strb_end)  st_nx = S_HOLD;
      S_HOLD:  if (ev_hold_end)  st_nx = S_RECOV;
      S_RECOV: if (ev_recov_end) st_nx = S_ACK;
      S_ACK:                     st_nx = S_IDLE;
      default:                   st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      wcnt <= '0;
      tot <= '0;
      lat_wr <= 1'b0;
      lat_byte <= 1'b0;
      lat_addr <= '0;
      lat_wdata <= '0;
      rdata <= '0;
      tmo_err <= 1'b0;
    end else begin
      st <= st_nx;
      if (ev_accept) begin
        lat_wr    <= req_wr;
        lat_byte  <= req_byte;
        lat_addr  <= req_addr;
        lat_wdata <= req_wdata;
        tmo_err   <= 1'b0;
        tot       <= '0;
      end else if (st != S_IDLE && st != S_ACK && tot != '1) begin
        tot <= tot + 1'b1;
      end
      if (st_nx != st)  cnt <= '0;
      else if (!stall)  cnt <= cnt + 1'b1;
      if (st != S_STRB) wcnt <= '0;
      else if (stall)   wcnt <= wcnt + 1'b1;
      if (ev_strb_end && !lat_wr) rdata <= dd_in;
      if (ev_timeout) tmo_err <= 1'b1;
    end
  end

  assign ack      = (st == S_ACK);
  assign addr_vld = (st == S_SETUP) || (st == S_STRB) || (st == S_HOLD);
  assign ata_addr = lat_addr;
  assign dd_out   = lat_wdata;
  assign dior_n   = !((st == S_STRB) && !lat_wr);
  assign diow_n   = !((st == S_STRB) && lat_wr);
  assign dd_oe    = lat_wr && ((st == S_SETUP) || (st == S_STRB) ||
                               ((st == S_HOLD) && (cnt < treg[SEL_T4])));

  // ---------------- assertions ----------------
  p_strobe_in_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!dior_n || !diow_n) |-> addr_vld);
  p_addr_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_vld && $past(addr_vld)) |-> $stable(ata_addr));
  p_no_oe_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !dior_n |-> !dd_oe);
  p_ack_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  p_stall_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !ev_timeout) |=> (st == S_STRB && $stable(cnt)));
  p_err_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_err) |-> $past(stall));
  p_cfg_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && $past(st != S_IDLE)) |-> ($stable(treg[SEL_T1]) && $stable(treg[SEL_T0])));
endmodule

// File: tb/pio_cycle_seq_tb_top.sv
module pio_cycle_seq_tb_top;
  localparam int CLK_P = 10;
  localparam int WD_LIMIT = 20000;
  // fields: wr, byte, t1, t2w, t2b, t2i, t4, t9, t0
  localparam int NV = 6;
  localparam int VEC [NV][9] = '{
    '{0, 0, 3, 5, 9, 2, 1, 2, 12},
    '{1, 0, 2, 4, 9, 1, 3, 1, 0},
    '{1, 1, 1, 2, 7, 4, 2, 5, 30},
    '{0, 1, 0, 3, 6, 0, 0, 0, 0},
    '{1, 0, 4, 6, 2, 3, 0, 2, 8},
    '{0, 0, 5, 8, 8, 6, 4, 3, 20}
  };

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [2:0] cfg_sel = 0; logic [7:0] cfg_val = 0;
  logic req = 0, req_wr = 0, req_byte = 0;
  logic [3:0] req_addr = 0; logic [15:0] req_wdata = 0;
  logic ack, tmo_err, addr_vld, dior_n, diow_n, dd_oe;
  logic [15:0] rdata, dd_out; logic [15:0] dd_in = 0;
  logic [3:0] ata_addr;
  logic iordy = 1;

  int total = 0, bad = 0;
  int m_setup, m_strb, m_hold, m_recov, m_oe_after, m_addr_bad, m_data_bad, m_dir_bad, m_ack_next, m_err;

  always #(CLK_P/2) clk = ~clk;

  pio_cycle_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_val(cfg_val),
    .req(req), .req_wr(req_wr), .req_byte(req_byte), .req_addr(req_addr), .req_wdata(req_wdata),
    .ack(ack), .rdata(rdata), .tmo_err(tmo_err), .ata_addr(ata_addr), .addr_vld(addr_vld),
    .dior_n(dior_n), .diow_n(diow_n), .dd_out(dd_out), .dd_oe(dd_oe), .dd_in(dd_in), .iordy(iordy)
  );

  function automatic int lmin1(input int v); return (v < 1) ? 1 : v; endfunction
  function automatic int imax(input int a, input int b); return (a > b) ? a : b; endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic setreg(input int sel, input int val);
    @(negedge clk); cfg_we = 1; cfg_sel = 3'(sel); cfg_val = 8'(val);
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic program_all(input int t1, t2w, t2b, t2i, t4, t9, t0, tmo);
    setreg(0, t1); setreg(1, t2w); setreg(2, t2b); setreg(3, t2i);
    setreg(4, t4); setreg(5, t9); setreg(6, t0); setreg(7, tmo);
  endtask

  // rel: -1 ready high, >=0 release in that strobe cycle, -2 never release
  task automatic run(input bit wr, input bit byt, input logic [3:0] a, input logic [15:0] wd,
                     input logic [15:0] rv, input int rel, input bit poke);
    bit seen = 0;
    m_setup = 0; m_strb = 0; m_hold = 0; m_recov = 0; m_oe_after = 0;
    m_addr_bad = 0; m_data_bad = 0; m_dir_bad = 0;
    @(negedge clk);
    req = 1; req_wr = wr; req_byte = byt; req_addr = a; req_wdata = wd; dd_in = rv;
    @(negedge clk);
    req = 0;
    if (poke) begin cfg_we = 1; cfg_sel = 3'd0; cfg_val = 8'd9; end
    for (int g = 0; g < 3000; g++) begin
      if (ack) break;
      if (addr_vld) begin
        if (ata_addr != a) m_addr_bad++;
        if (wr && !dior_n) m_dir_bad++;
        if (!wr && !diow_n) m_dir_bad++;
        if (!dior_n || !diow_n) begin
          m_strb++; seen = 1;
          if (wr && (!dd_oe || dd_out != wd)) m_data_bad++;
          if (rel >= 0 && m_strb == rel + 1) iordy = 1;
        end else if (!seen) begin
          m_setup++;
          if (wr && !dd_oe) m_data_bad++;
        end else begin
          m_hold++; dd_in = ~rv;
          if (dd_oe) m_oe_after++;
        end
      end else begin
        m_recov++;
        if (dd_oe) m_oe_after++;
      end
      @(negedge clk);
      cfg_we = 0;
    end
    m_err = tmo_err;
    @(negedge clk);
    m_ack_next = ack;
    iordy = 1;
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=0", WD_LIMIT);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 dior_n", dior_n, 1); chk("R1 diow_n", diow_n, 1);
    chk("R1 addr_vld", addr_vld, 0); chk("R1 dd_oe", dd_oe, 0);
    chk("R1 ack", ack, 0); chk("R1 tmo_err", tmo_err, 0);

    // table walk: R2 R3 R4 R5 R6 R7 R8 R12
    for (int i = 0; i < NV; i++) begin
      int wr, byt, t1, t2w, t2b, t2i, t4, t9, t0, e_set, e_str, e_hold, act, e_rec;
      logic [15:0] wd, rv;
      wr = VEC[i][0]; byt = VEC[i][1]; t1 = VEC[i][2]; t2w = VEC[i][3]; t2b = VEC[i][4];
      t2i = VEC[i][5]; t4 = VEC[i][6]; t9 = VEC[i][7]; t0 = VEC[i][8];
      wd = 16'hA500 + 16'(i); rv = 16'h3C10 + 16'(i * 7);
      program_all(t1, t2w, t2b, t2i, t4, t9, t0, 100);
      run(wr[0], byt[0], 4'(i + 3), wd, rv, -1, 0);
      e_set = lmin1(t1);
      e_str = lmin1(byt != 0 ? t2b : t2w);
      e_hold = (wr != 0) ? lmin1(imax(t9, t4)) : lmin1(t9);
      act = e_set + e_str + e_hold;
      e_rec = imax(lmin1(t2i), t0 - act);
      chk("R2 setup cycles", m_setup, e_set);
      chk("R3 strobe cycles", m_strb, e_str);
      chk("R3 strobe direction", m_dir_bad, 0);
      chk("R4 hold cycles", m_hold, e_hold);
      chk("R4 address", m_addr_bad, 0);
      chk("R5 data hold cycles", m_oe_after, (wr != 0) ? t4 : 0);
      chk("R5 data drive", m_data_bad, 0);
      chk("R6 recovery cycles", m_recov, e_rec);
      chk("R7 ack one cycle", m_ack_next, 0);
      if (wr == 0) chk("R8 read capture", int'(rdata), int'(rv));
    end

    // R9 stretch: release in strobe cycle 4
    program_all(2, 3, 3, 1, 1, 1, 0, 40);
    @(negedge clk); iordy = 0; repeat (3) @(negedge clk);
    run(0, 0, 4'h5, 16'h0, 16'h1234, 4, 0);
    chk("R9 stretched strobe", m_strb, 4 + 2 + 3);
    chk("R9 no error", m_err, 0);
    chk("R8 capture after stretch", int'(rdata), 16'h1234);

    // R10 timeout
    setreg(7, 6);
    @(negedge clk); iordy = 0; repeat (3) @(negedge clk);
    run(1, 0, 4'h2, 16'hBEEF, 16'h0, -2, 0);
    chk("R10 timeout strobe", m_strb, 6);
    chk("R10 err set", m_err, 1);
    repeat (3) @(negedge clk);
    chk("R10 err holds", tmo_err, 1);
    run(0, 1, 4'h1, 16'h0, 16'h0042, -1, 0);
    chk("R10 err cleared", m_err, 0);

    // R11 write while busy ignored (t1 is 2)
    run(0, 0, 4'h7, 16'h0, 16'h0, -1, 1);
    chk("R11 setup during poke", m_setup, 2);
    run(1, 0, 4'h7, 16'h5A5A, 16'h0, -1, 0);
    chk("R11 setup after poke", m_setup, 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule